// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block turns the system bus clock into the timing strobes a SPI master's shift engine needs. It first halves the bus clock to form a reference. It can then pass that reference through a fixed divide-by-16 stage, which is chosen per chip select. A 4-bit programmable prescaler follows, and a last divide-by-two sets the two halves of the serial clock period to equal length. The block does not produce a clock net. Instead it gives single-cycle strobes in the bus clock domain: one on every serial clock toggle, split into a leading-edge strobe and a trailing-edge strobe.

Each of the chip selects has its own prescale value and its own divide-by-16 select, so each attached device can run at its own rate. The shift engine raises `run` for the length of a frame. While `run` is low, every divider is held cleared. The block also keeps sampling the configuration for the chip select chosen by `cs_sel`. That setting is frozen when `run` rises, so a rate change made during a frame never stretches or cuts a character.

Top module: `spi_baud_gen`

## Requirements
- R1: While `rst` is high, `sclk_tick`, `sclk_lead` and `sclk_trail` read 0 on the following cycle.
- R2: With divide-by-16 off, consecutive toggle strobes are 2*(PM+1) bus clock cycles apart, where PM is the selected 4-bit prescale value.
- R3: With divide-by-16 on, consecutive toggle strobes are 32*(PM+1) bus clock cycles apart.
- R4: PM covers the full range 0 to 15. PM=0 gives the fastest rate (a toggle every 2 cycles), and PM=15 gives a toggle every 32 cycles, or every 512 cycles with divide-by-16.
- R5: Chip select i takes its prescale value from `cs_pm[4*i+3:4*i]` and its divide-by-16 select from `cs_div16[i]`. `cs_sel` picks i.
- R6: While `run` is low, no strobe is produced on the following cycles. After `run` rises, counting restarts from zero: the first toggle strobe is seen after the K-th rising clock edge with `run` high, where K is the toggle interval.
- R7: Each edge strobe lasts one cycle and strobes never overlap. Within a frame the first strobe is a leading strobe, and leading and trailing strobes then alternate strictly.
- R8: The configuration is captured only while `run` is low. Changes to `cs_sel`, `cs_pm` or `cs_div16` while `run` is high have no effect on the current frame.
- R9: `sclk_tick` is high exactly when either `sclk_lead` or `sclk_trail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Frame enable; low holds dividers cleared and opens configuration capture |
| cs_sel | input | 2 | Selected chip select index |
| cs_pm | input | 16 | Packed 4-bit prescale values, one per chip select |
| cs_div16 | input | 4 | Divide-by-16 select, one bit per chip select |
| sclk_tick | output | 1 | One-cycle strobe on every serial clock toggle |
| sclk_lead | output | 1 | One-cycle strobe on the leading serial clock edge |
| sclk_trail | output | 1 | One-cycle strobe on the trailing serial clock edge |

## Verification
Frames are run with the two extreme prescale values and with middle values, each with divide-by-16 both on and off. Comparing these separates the prescaler's compare width from the fixed stage's ratio and from the reference halving. Each frame uses a different chip select, and the other lanes are loaded with unrelated settings, so reading the wrong lane or the wrong bit field would change the period. One frame changes the configuration in the middle, which shows whether sampling is frozen. A frame cut short before its first toggle, followed straight away by a full frame, shows whether the counters restart when `run` rises.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;

    localparam int BRG_PM_W    = 4;
    localparam int BRG_REF_DIV = 2;
    localparam int BRG_PRE_DIV = 16;

    typedef struct packed {
        logic                div16;
        logic [BRG_PM_W-1:0] pm;
    } brg_cfg_t;

    typedef struct packed {
        logic tick;
        logic lead;
        logic trail;
    } brg_strobe_t;

    function automatic int brg_cnt_width(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/spi_brg_cfg_latch.sv
module spi_brg_cfg_latch
    import spi_brg_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic [CS_W-1:0]              cs_sel,
    input  logic [NUM_CS*BRG_PM_W-1:0]   cs_pm,
    input  logic [NUM_CS-1:0]            cs_div16,
    output brg_cfg_t                     cfg_q
);

    brg_cfg_t lane [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_lane
        assign lane[i].pm    = cs_pm[i*BRG_PM_W +: BRG_PM_W];
        assign lane[i].div16 = cs_div16[i];
    end

    // Sampling is open only between frames.
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (!run)
            cfg_q <= lane[cs_sel];
    end

endmodule

// File: rtl/spi_brg_divstage.sv
module spi_brg_divstage
    import spi_brg_pkg::*;
#(
    parameter int RATIO = 2,
    localparam int CW = brg_cnt_width(RATIO)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic en_in,
    input  logic bypass,
    output logic en_out
);

    if (RATIO > 1) begin : g_div
        localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst || !run)
                cnt <= '0;
            else if (en_in && !bypass)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end

        assign en_out = en_in && (bypass || cnt == LAST);
    end else begin : g_pass
        logic unused_sig;
        assign unused_sig = &{clk, rst, run, bypass};
        assign en_out = en_in;
    end

endmodule

// File: rtl/spi_brg_prescale.sv
module spi_brg_prescale
    import spi_brg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                en_in,
    input  logic [BRG_PM_W-1:0] pm,
    output logic                toggle
);

    logic [BRG_PM_W-1:0] pm_cnt;
    logic                hit;

    assign hit    = (pm_cnt == pm);
    assign toggle = en_in && hit;

    always_ff @(posedge clk) begin
        if (rst || !run)
            pm_cnt <= '0;
        else if (en_in)
            pm_cnt <= hit ? '0 : pm_cnt + 1'b1;
    end

endmodule

// File: rtl/spi_brg_edges.sv
module spi_brg_edges
    import spi_brg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        toggle,
    output brg_strobe_t strobe_q
);

    logic lvl;  // current serial clock phase: 0 = idle level

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            lvl      <= 1'b0;
            strobe_q <= '0;
        end else begin
            strobe_q.tick  <= toggle;
            strobe_q.lead  <= toggle && !lvl;
            strobe_q.trail <= toggle && lvl;
            if (toggle)
                lvl <= !lvl;
        end
    end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
    import spi_brg_pkg::*;
#(
    parameter int NUM_CS = 4,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic [CS_W-1:0]            cs_sel,
    input  logic [NUM_CS*BRG_PM_W-1:0] cs_pm,
    input  logic [NUM_CS-1:0]          cs_div16,
    output logic                       sclk_tick,
    output logic                       sclk_lead,
    output logic                       sclk_trail
);

    brg_cfg_t    cfg;
    brg_strobe_t strobe;
    logic        ref_en;
    logic        pre_en;
    logic        tog;

    spi_brg_cfg_latch #(.NUM_CS(NUM_CS)) u_cfg (
        .clk(clk), .rst(rst), .run(run),
        .cs_sel(cs_sel), .cs_pm(cs_pm), .cs_div16(cs_div16),
        .cfg_q(cfg)
    );

    // Reference: half the bus clock.
    spi_brg_divstage #(.RATIO(BRG_REF_DIV)) u_ref (
        .clk(clk), .rst(rst), .run(run),
        .en_in(run), .bypass(1'b0), .en_out(ref_en)
    );

    // Optional fixed divide-by-16.
    spi_brg_divstage #(.RATIO(BRG_PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .run(run),
        .en_in(ref_en), .bypass(!cfg.div16), .en_out(pre_en)
    );

    spi_brg_prescale u_pm (
        .clk(clk), .rst(rst), .run(run),
        .en_in(pre_en), .pm(cfg.pm), .toggle(tog)
    );

    spi_brg_edges u_edge (
        .clk(clk), .rst(rst), .run(run),
        .toggle(tog), .strobe_q(strobe)
    );

    assign sclk_tick  = strobe.tick;
    assign sclk_lead  = strobe.lead;
    assign sclk_trail = strobe.trail;

endmodule

// File: rtl/spi_brg_checker.sv
module spi_brg_checker (
    input logic clk,
    input logic rst,
    input logic run,
    input logic sclk_tick,
    input logic sclk_lead,
    input logic sclk_trail
);

    logic lead_open;

    always_ff @(posedge clk) begin
        if (rst || !run)
            lead_open <= 1'b0;
        else if (sclk_lead)
            lead_open <= 1'b1;
        else if (sclk_trail)
            lead_open <= 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sclk_tick && !sclk_lead && !sclk_trail));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!sclk_tick && !sclk_lead && !sclk_trail));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sclk_lead, sclk_trail}));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        sclk_tick |=> !sclk_tick);

    assert_lead_first_R7: assert property (@(posedge clk) disable iff (rst)
        sclk_lead |-> !lead_open);

    assert_trail_after_lead_R7: assert property (@(posedge clk) disable iff (rst)
        sclk_trail |-> lead_open);

endmodule

bind spi_baud_gen spi_brg_checker u_brg_chk (
    .clk(clk), .rst(rst), .run(run),
    .sclk_tick(sclk_tick), .sclk_lead(sclk_lead), .sclk_trail(sclk_trail)
);

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;

    typedef struct {
        int    cyc;
        bit    lead;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [1:0]  cs_sel = '0;
    logic [15:0] cs_pm = '0;
    logic [3:0]  cs_div16 = '0;
    logic        sclk_tick, sclk_lead, sclk_trail;

    int   checks = 0;
    int   fails  = 0;
    int   fcyc   = 0;
    int   cycles = 0;
    bit   done   = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    spi_baud_gen u_spi_baud_gen (
        .clk(clk), .rst(rst), .run(run),
        .cs_sel(cs_sel), .cs_pm(cs_pm), .cs_div16(cs_div16),
        .sclk_tick(sclk_tick), .sclk_lead(sclk_lead), .sclk_trail(sclk_trail)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst || !run) fcyc <= 0;
        else             fcyc <= fcyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a strobe appears.
    always @(negedge clk) begin
        if (!rst && !done && (sclk_tick || sclk_lead || sclk_trail)) begin
            check(sclk_tick == (sclk_lead || sclk_trail), "R9", "tick vs edges",
                  int'(sclk_tick), int'(sclk_lead || sclk_trail));
            if (sb.size() == 0) begin
                check(0, "R6", "unexpected strobe at frame cycle", fcyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(fcyc == e.cyc, e.req, "strobe cycle", fcyc, e.cyc);
                check(sclk_lead == e.lead && sclk_trail == !e.lead, "R7",
                      "edge kind lead", int'(sclk_lead), int'(e.lead));
            end
        end
    end

    // Driver: loads config for one chip select, pushes expected strobes, runs the frame.
    task automatic frame(input int cs, input int pm, input bit d16, input int len,
                         input bit mid_change, input string req);
        int per;
        int m;
        for (int i = 0; i < 4; i++) begin
            cs_pm[i*4 +: 4] = 4'(7 + i);
            cs_div16[i]     = 1'b0;
        end
        cs_pm[cs*4 +: 4] = 4'(pm);
        cs_div16[cs]     = d16;
        cs_sel           = 2'(cs);
        repeat (3) @(negedge clk);
        per = 2 * (pm + 1) * (d16 ? 16 : 1);
        m = 1;
        while (m * per <= len) begin
            exp_t e;
            e.cyc  = m * per;
            e.lead = (m % 2) == 1;
            e.req  = req;
            sb.push_back(e);
            m++;
        end
        run = 1'b1;
        if (mid_change) begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            cs_pm    = 16'h0000;
            cs_div16 = 4'hF;
            cs_sel   = 2'(cs ^ 1);
            repeat (len - 3) @(posedge clk);
        end else begin
            repeat (len) @(posedge clk);
        end
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, req, "missing strobes", sb.size(), 0);
        sb.delete();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(!sclk_tick && !sclk_lead && !sclk_trail, "R1", "outputs in reset",
              int'({sclk_tick, sclk_lead, sclk_trail}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!sclk_tick && !sclk_lead && !sclk_trail, "R6", "idle outputs",
              int'({sclk_tick, sclk_lead, sclk_trail}), 0);

        frame(0, 0,  1'b0, 12,   1'b0, "R4");  // fastest rate
        frame(1, 3,  1'b0, 40,   1'b0, "R2");
        frame(2, 15, 1'b0, 100,  1'b0, "R4");
        frame(3, 1,  1'b1, 200,  1'b0, "R3");
        frame(0, 15, 1'b1, 1100, 1'b0, "R3");  // slowest rate
        frame(2, 5,  1'b0, 30,   1'b0, "R5");
        frame(1, 2,  1'b0, 40,   1'b1, "R8");  // config change mid-frame ignored
        frame(3, 3,  1'b0, 5,    1'b0, "R6");  // cut short before first toggle
        frame(3, 3,  1'b0, 9,    1'b0, "R6");  // restart from zero

        rst = 1'b1;
        run = 1'b1;
        repeat (2) @(negedge clk);
        check(!sclk_tick && !sclk_lead && !sclk_trail, "R1", "reset overrides run",
              int'({sclk_tick, sclk_lead, sclk_trail}), 0);
        run = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(negedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule